// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block watches over a small 8-bit controller. The oscillator clock passes through a fixed divide-by-12 stage that marks machine cycles. A power-of-two prescaler chosen by software divides those machine cycles again, and its output advances a 14-bit counter. Each time the counter wraps, the block gives a one-machine-cycle timeout flag. If the watchdog is armed, the block also gives a two-machine-cycle internal reset and clears its own control byte.

Firmware drives the block through a single control byte on the special-function register bus. The byte holds an arm bit, a restart bit that clears itself, a bit that keeps counting while the core idles, and a 3-bit divider select. Code that is running correctly keeps writing the restart bit before the counter can wrap. The timeout flag pulses on every wrap even when the block is not armed, so the block also works as a periodic time base. The idle status from power management stops the count unless the idle-run bit is set.

Top module: `wdog_top`

## Requirements
- R1: The control byte answers at bus address 0x8F. Its bits are: bit 7 arm, bit 6 restart, bit 5 idle-run, bits 2:0 divider select. Bits 4:3 always read 0. A read at any other address returns 0, and a write to any other address leaves the byte unchanged.
- R2: After the external reset, the control byte reads 0x00 and both the timeout flag and the internal reset are low.
- R3: While counting runs freely, consecutive timeout flags are exactly 2^CNT_W × 2^(sel+1) × 12 clock cycles apart. The divider select value sel is in the range 0 to 7.
- R4: Writing 1 to the restart bit clears the prescaler and the counter at the next machine-cycle boundary, and the bit then reads 0. The next timeout follows the write after between one period and one period plus 12 cycles.
- R5: At each counter wrap the timeout flag is high for exactly 12 clock cycles (one machine cycle), whether or not the block is armed.
- R6: A wrap raises the internal reset only when the arm bit is 1. The reset then lasts 24 clock cycles (two machine cycles), and the control byte reads 0x00 afterwards.
- R7: While the idle input is high and idle-run is 0, the counter holds its value. Counting resumes when idle falls, so the timeout is delayed by the length of the idle period.
- R8: While idle-run is 1, a high idle input has no effect on the timeout period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | 8 | Register bus read data, combinational |
| idle_i | input | 1 | Core is in idle mode |
| tmo_o | output | 1 | Timeout flag, one machine cycle per wrap |
| wd_rst_o | output | 1 | Internal reset request, two machine cycles |

## Verification
The assertions check these properties on every cycle. A restart empties the counter at the machine-cycle boundary that follows. The counter does not move during an idle period that is not allowed to count. Every rising timeout flag coincides with the counter at zero. The flag never stays high longer than one machine cycle. A rising internal reset always follows an armed control byte, and the control byte is already cleared when that reset rises. Only the bench's scenarios can show the absolute spacing of timeouts for each divider setting, how long an idle period delays the timeout, the exact widths of both pulses, and how the control byte reads back through the bus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] WDC_ADDR = 8'h8F;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             arm;
    logic             restart;
    logic             idle_run;
    logic [SEL_W-1:0] sel;
  } wdc_t;

  function automatic logic [7:0] wdc_to_byte(input wdc_t c);
    return {c.arm, c.restart, c.idle_run, 2'b00, c.sel};
  endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter logic [7:0] ADDR = WDC_ADDR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       mc_tick,
  input  logic       kill,
  output wdc_t       ctrl_o
);
  wdc_t ctrl_q, ctrl_d;
  logic hit;
  logic unused_bits;

  assign hit         = we && (addr == ADDR);
  assign unused_bits = ^wdata[4:3];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.restart && mc_tick) ctrl_d.restart = 1'b0;
    if (hit) begin
      ctrl_d.arm      = wdata[7];
      ctrl_d.restart  = wdata[6];
      ctrl_d.idle_run = wdata[5];
      ctrl_d.sel      = wdata[SEL_W-1:0];
    end
    if (kill) ctrl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int MC_DIV = 12,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             mc_tick_o,
  output logic             cnt_tick_o
);
  localparam int MCW   = $clog2(MC_DIV);
  localparam int PRE_W = 1 << SEL_W;
  localparam int NSEL  = 1 << SEL_W;

  logic [MCW-1:0]   mc_q, mc_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask_tbl [NSEL];
  logic [PRE_W-1:0] mask;
  logic             mc_tick;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask_tbl[g] = PRE_W'((64'd1 << (g + 1)) - 64'd1);
  end

  assign mask    = mask_tbl[sel];
  assign mc_tick = (mc_q == MCW'(MC_DIV - 1));

  always_comb begin
    mc_d = mc_tick ? '0 : mc_q + 1'b1;
  end

  always_comb begin
    pre_d = pre_q;
    if (mc_tick) begin
      if (clr)      pre_d = '0;
      else if (run) pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= '0;
      pre_q <= '0;
    end else begin
      mc_q  <= mc_d;
      pre_q <= pre_d;
    end
  end

  assign mc_tick_o  = mc_tick;
  assign cnt_tick_o = run && mc_tick && !clr && ((pre_q & mask) == mask);

  assert_mc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mc_q <= MCW'(MC_DIV - 1));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = tick && (&cnt_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int MC_DIV = 12,
  parameter int RST_MC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_tick,
  input  logic ovf,
  input  logic arm,
  output logic tmo_o,
  output logic rst_o
);
  localparam int RW = $clog2(RST_MC + 1);
  localparam int TW = $clog2(MC_DIV + 2);

  logic          tmo_q, tmo_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    tmo_d = tmo_q;
    if (ovf)          tmo_d = 1'b1;
    else if (mc_tick) tmo_d = 1'b0;
  end

  always_comb begin
    rcnt_d = rcnt_q;
    if (ovf && arm)                    rcnt_d = RW'(RST_MC);
    else if (mc_tick && rcnt_q != '0)  rcnt_d = rcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      tmo_q  <= tmo_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign tmo_o = tmo_q;
  assign rst_o = (rcnt_q != '0);

  logic [TW-1:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_run <= '0;
    else if (tmo_q) chk_run <= chk_run + 1'b1;
    else            chk_run <= '0;
  end

  assert_tmo_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_run <= TW'(MC_DIV));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int MC_DIV = 12,
  parameter int CNT_W  = 14,
  parameter int RST_MC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  output logic [7:0] sfr_rdata,
  input  logic       idle_i,
  output logic       tmo_o,
  output logic       wd_rst_o
);
  logic [1:0]       sync_q;
  logic             srst_n;
  wdc_t             ctrl;
  logic             mc_tick, cnt_tick, ovf, run, clr;
  logic             kill;
  logic [CNT_W-1:0] cnt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  assign run  = !idle_i || ctrl.idle_run;
  assign clr  = ctrl.restart && mc_tick;
  assign kill = ovf && ctrl.arm;

  wdog_ctrl_reg #(.ADDR(WDC_ADDR)) u_reg (
    .clk(clk), .rst_n(srst_n), .we(sfr_we), .addr(sfr_addr),
    .wdata(sfr_wdata), .mc_tick(mc_tick), .kill(kill), .ctrl_o(ctrl)
  );

  wdog_prescaler #(.MC_DIV(MC_DIV), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(srst_n), .run(run), .clr(clr), .sel(ctrl.sel),
    .mc_tick_o(mc_tick), .cnt_tick_o(cnt_tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .clr(clr), .tick(cnt_tick),
    .cnt_o(cnt_val), .ovf_o(ovf)
  );

  wdog_pulse #(.MC_DIV(MC_DIV), .RST_MC(RST_MC)) u_pulse (
    .clk(clk), .rst_n(srst_n), .mc_tick(mc_tick), .ovf(ovf),
    .arm(ctrl.arm), .tmo_o(tmo_o), .rst_o(wd_rst_o)
  );

  assign sfr_rdata = (sfr_addr == WDC_ADDR) ? wdc_to_byte(ctrl) : 8'h00;

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl.restart && mc_tick) |=> (cnt_val == '0));

  assert_idle_freeze_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (idle_i && !ctrl.idle_run && !(ctrl.restart && mc_tick)) |=> $stable(cnt_val));

  assert_tmo_at_wrap_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(tmo_o) |-> (cnt_val == '0));

  assert_rst_needs_arm_R6: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wd_rst_o) |-> $past(ctrl.arm));

  assert_rst_clears_ctrl_R6: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wd_rst_o) |-> (ctrl == '0));
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  localparam int MC  = 12;
  localparam int CW  = 5;
  localparam int P0  = (1 << CW) * 2 * MC;
  localparam int P1  = (1 << CW) * 4 * MC;
  localparam int P2  = (1 << CW) * 8 * MC;
  localparam int LIMIT = 150000;

  logic       clk;
  logic       rst_n;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_we, idle_i, tmo_o, wd_rst_o;

  int checks, errors, cyc, ref_cyc, tmo_w, rst_w;
  bit armed, prev_tmo, prev_rst, done;

  typedef struct { int lo; int hi; bit rst; string tag; } exp_t;
  exp_t q[$];

  wdog_top #(.MC_DIV(MC), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .idle_i(idle_i),
    .tmo_o(tmo_o), .wd_rst_o(wd_rst_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    ref_cyc = cyc + 1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic push(input int lo, input int hi, input bit r, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.rst = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // monitor: pops expected timeouts and checks pulse widths
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmo_o && !prev_tmo) begin
        if (q.size() != 0) begin
          exp_t e;
          e = q.pop_front();
          check_rng({e.tag, " interval"}, cyc - ref_cyc, e.lo, e.hi);
          check({"R6 reset gating ", e.tag}, int'(wd_rst_o), int'(e.rst));
        end else if (armed) begin
          check("R3 unexpected timeout", 1, 0);
        end
        ref_cyc = cyc;
      end
      if (tmo_o) tmo_w++;
      else if (prev_tmo) begin
        if (armed) check("R5 flag width", tmo_w, MC);
        tmo_w = 0;
      end
      if (wd_rst_o) rst_w++;
      else if (prev_rst) begin
        check("R6 reset width", rst_w, 2 * MC);
        rst_w = 0;
      end
      prev_tmo = tmo_o;
      prev_rst = wd_rst_o;
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    checks = 0; errors = 0; cyc = 0; ref_cyc = 0; tmo_w = 0; rst_w = 0;
    armed = 0; prev_tmo = 0; prev_rst = 0; done = 0;
    rst_n = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00; sfr_we = 1'b0; idle_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    rd(8'h8F, d);
    check("R2 control after reset", d, 8'h00);
    check("R2 timeout low", int'(tmo_o), 0);
    check("R2 internal reset low", int'(wd_rst_o), 0);

    // R1 readback, reserved bits, foreign address ignored
    wr(8'h8F, 8'h3F);
    rd(8'h8F, d);
    check("R1 readback reserved zero", d, 8'h27);
    wr(8'h8E, 8'hFF);
    rd(8'h8F, d);
    check("R1 other address ignored", d, 8'h27);
    rd(8'h8E, d);
    check("R1 other address reads zero", d, 8'h00);

    // R4 restart, then R3 free-running period, sel 0
    armed = 1;
    wr(8'h8F, 8'h40);
    push(P0, P0 + MC, 0, "R4 restart");
    push(P0, P0, 0, "R3 sel0");
    push(P0, P0, 0, "R3 sel0 again");
    repeat (14) @(negedge clk);
    rd(8'h8F, d);
    check("R4 restart self clears", d, 8'h00);
    drain();

    // R3 sel 1
    wr(8'h8F, 8'h41);
    push(P1, P1 + MC, 0, "R4 restart sel1");
    push(P1, P1, 0, "R3 sel1");
    drain();

    // R6 armed timeout: reset pulse, control cleared, then unarmed wrap
    wr(8'h8F, 8'hC0);
    push(P0, P0 + MC, 1, "R6 armed");
    push(P0, P0, 0, "R6 after disarm");
    while (q.size() == 2) @(negedge clk);
    repeat (30) @(negedge clk);
    rd(8'h8F, d);
    check("R6 control cleared by reset", d, 8'h00);
    drain();

    // R7 idle halts counting
    wr(8'h8F, 8'h42);
    push(P2 + 1200 - 2 * MC, P2 + 1200 + 2 * MC, 0, "R7 idle halt");
    @(negedge clk); idle_i = 1'b1;
    repeat (1200) @(negedge clk);
    idle_i = 1'b0;
    drain();

    // R8 idle-run keeps counting
    idle_i = 1'b1;
    wr(8'h8F, 8'h60);
    push(P0, P0 + MC, 0, "R8 idle run");
    push(P0, P0, 0, "R8 idle run again");
    drain();
    idle_i = 1'b0;
    armed = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule